// File: doc/BRIEF.md
# Privilege-Filtered Event Counter

This block is one performance-monitor event counter paired with its own programmable event-type register. On every clock it receives a vector of single-cycle event pulses, the exception level the processor is running at (EL0 to EL3) and a flag that says whether that level runs in the non-secure state. The type register picks one event number and holds six privilege filter bits. The counter adds one on a clock edge when the chosen event pulse is high and the filter bits allow counting at the current level and security state.

Software, or a surrounding register block, writes the type register or the counter through a single write port, and reads either one back through a combinational read port. The filter treats each level differently. Secure EL0 and EL1 use a plain block bit. Non-secure EL0 and EL1 count only when a pair of bits are equal. EL2 uses a plain allow bit. EL3 compares its own bit with the EL1 block bit.

Top module: `priv_event_counter`

## Requirements
- R1: After a synchronous active-low reset, the type register and the counter both read as zero.
- R2: A write with `wr_sel`=0 loads the type register. Bits 31:26 (filter bits) and bits 9:0 (event number) are stored. Bits 25:10 are dropped and always read as zero.
- R3: The event number selects bit `evt_pulse[n]` for n in 0..15. Any number of 16 or above never counts, and it still reads back exactly as it was written.
- R4: In the secure state, EL0 counts only when bit 30 is 0 and EL1 counts only when bit 31 is 0 (`cur_el` encodes EL0..EL3 as 0..3; `non_secure`=0 means secure).
- R5: In the non-secure state, EL0 counts only when bit 28 equals bit 30, and EL1 counts only when bit 29 equals bit 31.
- R6: At EL2, counting happens only when bit 27 is 1, whatever the value of `non_secure`.
- R7: At EL3, counting happens only when bit 26 equals bit 31, whatever the value of `non_secure`.
- R8: The 32-bit counter wraps from all ones to zero on an increment.
- R9: A counter write (`wr_en`=1, `wr_sel`=1) in the same cycle as a counted event loads the written value, and the event is lost.
- R10: An event sampled at clock edge n is visible on the read port after edge n and not before it. The filter sees a type-register write from the edge after that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| evt_pulse | input | 16 | Event pulses, bit n is event number n |
| cur_el | input | 2 | Current exception level, 0..3 |
| non_secure | input | 1 | 1 = non-secure state, 0 = secure |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 type register, 1 counter |
| wr_data | input | 32 | Write data |
| rd_sel | input | 1 | Read source: 0 type register, 1 counter |
| rd_data | output | 32 | Read data, combinational |

## Verification
The assertions assume that `evt_pulse`, `cur_el` and `non_secure` are stable around each rising edge. They also assume that reset is held for at least one edge before any write, so the previous-cycle values they look at are the reset values. The bench changes every input only on the falling clock edge. It keeps `wr_en` low during reset. It drives event pulses only in cycles without a write, except for the one cycle that deliberately tests write priority.

// File: rtl/pmon_pkg.sv
// Package: shared types and field positions of the event-type register.
// Assumes a 32-bit register word. Filter bits sit at the top six bits.
package pmon_pkg;
    localparam int TYPE_W   = 32;
    localparam int SEL_W    = 10;
    localparam int BIT_P    = 31;
    localparam int BIT_U    = 30;
    localparam int BIT_NSK  = 29;
    localparam int BIT_NSU  = 28;
    localparam int BIT_NSH  = 27;
    localparam int BIT_M    = 26;

    typedef enum logic [1:0] {
        LVL_EL0 = 2'd0,
        LVL_EL1 = 2'd1,
        LVL_EL2 = 2'd2,
        LVL_EL3 = 2'd3
    } exc_level_e;

    typedef struct packed {
        logic p;
        logic u;
        logic nsk;
        logic nsu;
        logic nsh;
        logic m;
    } filt_bits_t;
endpackage

// File: rtl/evtype_reg.sv
// Module: event-type register. It stores the filter bits and the event
// number, and it drops the reserved span on write.
// Assumes that wr_en is a single-cycle strobe qualified by the caller.
module evtype_reg
    import pmon_pkg::*;
#(
    parameter int SEL_BITS = SEL_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [TYPE_W-1:0]    wr_data,
    output filt_bits_t           filt,
    output logic [SEL_BITS-1:0]  evt_sel,
    output logic [TYPE_W-1:0]    type_word
);
    localparam int RESV_W = BIT_M - SEL_BITS;

    filt_bits_t          filt_q;
    logic [SEL_BITS-1:0] sel_q;
    logic                unused_resv;

    // Load the filter bits and the event number on a type write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            filt_q <= '0;
            sel_q  <= '0;
        end else if (wr_en) begin
            filt_q <= filt_bits_t'(wr_data[TYPE_W-1:BIT_M]);
            sel_q  <= wr_data[SEL_BITS-1:0];
        end
    end

    // The reserved span is not stored.
    assign unused_resv = ^wr_data[BIT_M-1:SEL_BITS];

    // Assemble the read-back word with the reserved span forced to zero.
    always_comb begin
        type_word = {filt_q, {RESV_W{1'b0}}, sel_q};
    end

    assign filt    = filt_q;
    assign evt_sel = sel_q;
endmodule

// File: rtl/priv_filter.sv
// Module: count-enable decision from the filter bits, the exception level
// and the security state. Purely combinational.
// Assumes that EL2 exists only non-secure and EL3 only secure, so at those
// two levels the security flag is ignored.
module priv_filter
    import pmon_pkg::*;
(
    input  filt_bits_t  filt,
    input  exc_level_e  level,
    input  logic        non_secure,
    output logic        allow
);
    // Pick the rule that applies to the current level and state.
    always_comb begin
        allow = 1'b0;
        unique case (level)
            LVL_EL0: allow = non_secure ? (filt.nsu == filt.u) : !filt.u;
            LVL_EL1: allow = non_secure ? (filt.nsk == filt.p) : !filt.p;
            LVL_EL2: allow = filt.nsh;
            LVL_EL3: allow = (filt.m == filt.p);
            default: allow = 1'b0;
        endcase
    end
endmodule

// File: rtl/event_select.sv
// Module: picks the pulse that the event number names. Numbers with no
// implemented event give no hit.
// Assumes that EVT_W does not exceed 2**SEL_BITS.
module event_select #(
    parameter int EVT_W    = 16,
    parameter int SEL_BITS = 10
) (
    input  logic [EVT_W-1:0]    evt_pulse,
    input  logic [SEL_BITS-1:0] evt_sel,
    output logic                hit
);
    logic [EVT_W-1:0] match;

    // One comparator per implemented event number.
    for (genvar gi = 0; gi < EVT_W; gi++) begin : g_match
        assign match[gi] = (evt_sel == SEL_BITS'(gi)) & evt_pulse[gi];
    end

    // At most one comparator matches, so an OR reduction is enough.
    assign hit = |match;
endmodule

// File: rtl/pmon_counter.sv
// Module: a wrapping event counter. A load has priority over an increment.
// Assumes that inc is already qualified by the filter and the event select.
module pmon_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt
);
    logic [CNT_W-1:0] cnt_q;

    // Load, or step by one and wrap at all ones.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (inc)
            cnt_q <= cnt_q + CNT_W'(1);
    end

    assign cnt = cnt_q;
endmodule

// File: rtl/priv_event_counter.sv
// Module: top of the privilege-filtered event counter. It ties the type
// register, the filter, the event select and the counter together and
// drives the combinational read mux.
// Assumes that the counter is exactly as wide as the register word.
module priv_event_counter
    import pmon_pkg::*;
#(
    parameter int EVT_W = 16,
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [EVT_W-1:0]  evt_pulse,
    input  logic [1:0]        cur_el,
    input  logic              non_secure,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [31:0]       wr_data,
    input  logic              rd_sel,
    output logic [31:0]       rd_data
);
    filt_bits_t        filt;
    logic [SEL_W-1:0]  evt_sel;
    logic [31:0]       type_word;
    logic              allow;
    logic              hit;
    logic [CNT_W-1:0]  cnt_val;

    evtype_reg #(.SEL_BITS(SEL_W)) u_type (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en && !wr_sel),
        .wr_data   (wr_data),
        .filt      (filt),
        .evt_sel   (evt_sel),
        .type_word (type_word)
    );

    priv_filter u_filt (
        .filt       (filt),
        .level      (exc_level_e'(cur_el)),
        .non_secure (non_secure),
        .allow      (allow)
    );

    event_select #(.EVT_W(EVT_W), .SEL_BITS(SEL_W)) u_sel (
        .evt_pulse (evt_pulse),
        .evt_sel   (evt_sel),
        .hit       (hit)
    );

    pmon_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (wr_en && wr_sel),
        .load_val (wr_data[CNT_W-1:0]),
        .inc      (hit && allow),
        .cnt      (cnt_val)
    );

    // Read mux: counter or type register.
    always_comb begin
        rd_data = rd_sel ? 32'(cnt_val) : type_word;
    end
endmodule

// File: rtl/pmon_chk.sv
// Module: assertion checker for priv_event_counter, attached through bind.
// Assumes that reset is held for at least one clock edge at start-up.
module pmon_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic        wr_sel,
    input logic [31:0] wr_data,
    input logic [1:0]  cur_el,
    input logic [31:0] type_word,
    input logic [31:0] cnt_val
);
    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (cnt_val == 32'd0 && type_word == 32'd0));

    // R2
    resv_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        type_word[25:10] == 16'd0);

    // R9
    load_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel) |=> (cnt_val == $past(wr_data)));

    // R8
    single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_sel) |=>
            (cnt_val == $past(cnt_val) || cnt_val == $past(cnt_val) + 32'd1));

    // R3
    unimpl_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(wr_en && wr_sel) && type_word[9:0] >= 10'd16) |=> $stable(cnt_val));

    // R6
    el2_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(wr_en && wr_sel) && cur_el == 2'd2 && !type_word[27]) |=> $stable(cnt_val));
endmodule

bind priv_event_counter pmon_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_sel    (wr_sel),
    .wr_data   (wr_data),
    .cur_el    (cur_el),
    .type_word (type_word),
    .cnt_val   (32'(cnt_val))
);

// File: tb/priv_event_counter_bench.sv
module priv_event_counter_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] evt_pulse = '0;
    logic [1:0]  cur_el = '0;
    logic        non_secure = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_sel = 1'b0;
    logic [31:0] wr_data = '0;
    logic        rd_sel = 1'b0;
    logic [31:0] rd_data;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    priv_event_counter u_priv_event_counter (
        .clk(clk), .rst_n(rst_n), .evt_pulse(evt_pulse), .cur_el(cur_el),
        .non_secure(non_secure), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic reg_write(input logic sel, input logic [31:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic reg_read(input logic sel, output logic [31:0] val);
        rd_sel = sel;
        #1;
        val = rd_data;
    endtask

    // Expected count enable, from the filter rules in R4..R7.
    function automatic logic exp_allow(input logic [5:0] f, input int el, input logic ns);
        logic p, u, nsk, nsu, nsh, m;
        {p, u, nsk, nsu, nsh, m} = f;
        case (el)
            0: return ns ? (nsu == u) : !u;
            1: return ns ? (nsk == p) : !p;
            2: return nsh;
            default: return (m == p);
        endcase
    endfunction

    // Pulse the given vector for one cycle, then return the counter value.
    task automatic pulse_and_read(input logic [15:0] vec, output logic [31:0] val);
        @(negedge clk);
        evt_pulse = vec;
        @(negedge clk);
        evt_pulse = '0;
        reg_read(1'b1, val);
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        reg_read(1'b0, v); chk("R1 type after reset", v, 32'h0);
        reg_read(1'b1, v); chk("R1 counter after reset", v, 32'h0);

        // R2: the reserved span is dropped.
        reg_write(1'b0, 32'hFFFF_FFFF);
        reg_read(1'b0, v); chk("R2 all-ones readback", v, 32'hFC00_03FF);
        reg_write(1'b0, 32'h5555_5555);
        reg_read(1'b0, v); chk("R2 pattern readback", v, 32'h5400_0155);

        // R4..R7: sweep every filter setting, level and security state.
        for (int f = 0; f < 64; f++) begin
            reg_write(1'b0, {f[5:0], 16'h0, 10'd5});
            for (int el = 0; el < 4; el++) begin
                for (int ns = 0; ns < 2; ns++) begin
                    string tag;
                    logic e;
                    reg_write(1'b1, 32'h0);
                    cur_el = el[1:0]; non_secure = ns[0];
                    pulse_and_read(16'h0020, v);
                    e = exp_allow(f[5:0], el, ns[0]);
                    if (el == 2) tag = "R6 EL2 filter";
                    else if (el == 3) tag = "R7 EL3 filter";
                    else if (ns == 1) tag = "R5 non-secure filter";
                    else tag = "R4 secure filter";
                    chk(tag, v, {31'h0, e});
                end
            end
        end

        // R3: event number select, secure EL0 with all filter bits clear.
        cur_el = 2'd0; non_secure = 1'b0;
        for (int k = 0; k < 20; k++) begin
            logic [15:0] one;
            one = (k < 16) ? (16'h1 << k) : 16'h0;
            reg_write(1'b0, {22'h0, k[9:0]});
            reg_write(1'b1, 32'h0);
            pulse_and_read(one, v);
            chk("R3 selected pulse counts", v, (k < 16) ? 32'd1 : 32'd0);
            pulse_and_read(~one, v);
            chk("R3 other pulses ignored", v, (k < 16) ? 32'd1 : 32'd0);
        end
        reg_write(1'b0, 32'h0000_03FF);
        reg_write(1'b1, 32'h0);
        pulse_and_read(16'hFFFF, v);
        chk("R3 unimplemented number counts nothing", v, 32'd0);
        reg_read(1'b0, v);
        chk("R3 unimplemented number reads back", v, 32'h0000_03FF);

        // R8: wrap at all ones.
        reg_write(1'b0, 32'd2);
        reg_write(1'b1, 32'hFFFF_FFFF);
        pulse_and_read(16'h0004, v);
        chk("R8 wrap to zero", v, 32'h0);

        // R9: a counter write wins over an event in the same cycle.
        @(negedge clk);
        evt_pulse = 16'h0004; wr_en = 1'b1; wr_sel = 1'b1; wr_data = 32'd77;
        @(negedge clk);
        evt_pulse = '0; wr_en = 1'b0;
        reg_read(1'b1, v);
        chk("R9 write beats increment", v, 32'd77);

        // R10: one-edge latency for an event.
        reg_write(1'b1, 32'd10);
        @(negedge clk);
        evt_pulse = 16'h0004;
        reg_read(1'b1, v);
        chk("R10 not visible before edge", v, 32'd10);
        @(negedge clk);
        evt_pulse = '0;
        reg_read(1'b1, v);
        chk("R10 visible after edge", v, 32'd11);

        // R10: the filter sees a type write from the next edge on.
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 1'b0; wr_data = 32'h8000_0002;
        cur_el = 2'd1; evt_pulse = 16'h0004;
        @(negedge clk);
        wr_en = 1'b0;
        @(negedge clk);
        evt_pulse = '0;
        reg_read(1'b1, v);
        chk("R10 old filter on write edge, new filter after", v, 32'd12);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule